// File: doc/BRIEF.md
# Register-Array Datapath with Microoperations

This block is the storage and arithmetic half of a small processor core. It holds an array of equal-width registers and a set of functional units. An outside control unit drives it with plain select signals. Two operand selectors pick the registers that feed the units. An operation code picks which unit's output goes onto a shared result bus. That bus loops back to the data input of every register. A decoder turns a destination index and a write strobe into per-register load enables, so only the addressed register captures the bus and every other register keeps its value.

Each clock cycle carries out one microoperation. A single-register operation uses operand A alone: move, load a zero constant, invert, or shift by one. A two-register operation combines A and B: add, subtract, AND, OR or XOR. An external-load operation puts an outside data word on the bus, so software running on the control unit can set register values without a memory. Additions and subtractions also record a carry/borrow flag. A separate read port with its own index shows the contents of any register.

Top module: `regarray_datapath`

## Requirements
- R1: An active-high synchronous reset `rst` clears every register and the carry flag to zero on the next rising edge. It takes precedence over a write in the same cycle.
- R2: When `wr_en` is high at a rising edge, the register indexed by `dst` takes the result bus value. `rd_data` follows `rd_sel` combinationally, so the new value shows on the read port right after that edge.
- R3: When `wr_en` is low at a rising edge, no register and not the carry flag change, whatever the other inputs are.
- R4: A write changes only the register indexed by `dst`. All other registers hold their contents.
- R5: `src_a` and `src_b` choose any two registers, the same one allowed, as operands A and B.
- R6: Single-register codes: 0 moves A, 1 loads the constant zero, 2 gives bitwise NOT of A, 3 shifts A left by one with a zero coming in at bit 0, and 4 shifts A right by one with a zero coming in at the top bit.
- R7: Two-register codes: 5 gives A+B and 6 gives A-B, both modulo 2^16. Codes 7, 8 and 9 give bitwise A AND B, A OR B and A XOR B.
- R8: A write with code 5 sets the carry flag to the carry out of bit 15. A write with code 6 sets it to 1 exactly when A < B unsigned (borrow). A write with any other code leaves the flag unchanged.
- R9: Code 10 puts `ext_data` on the result bus. Codes 11 to 15 put zero on it.
- R10: When the destination is also an operand, the operation uses the register's value from before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all registers |
| rst | input | 1 | Synchronous active-high clear |
| wr_en | input | 1 | Write strobe for the destination register |
| src_a | input | 3 | Register index for operand A |
| src_b | input | 3 | Register index for operand B |
| dst | input | 3 | Register index that receives the result |
| op | input | 4 | Microoperation code |
| ext_data | input | 16 | External value used by code 10 |
| rd_sel | input | 3 | Register index for the read port |
| rd_data | output | 16 | Contents of the register at `rd_sel` |
| carry | output | 1 | Carry/borrow flag from the last add or subtract write |

## Verification
The bench targets these corner cases:
- Sums that pass 16 bits, and subtractions with A below B. A wrong carry or borrow polarity shows up on `carry` at once.
- Logic and shift writes that follow an add. A flag that updates on every write would be caught here.
- Shifts of values with the top or bottom bit set. An arithmetic shift or a rotate leaves a bit that should be zero.
- A reset raised together with a write, which must clear rather than store.
- Operations whose destination is also an operand, which must use the value from before the edge.
- A strobe-low cycle with a live operation code. A decoder that ignores the strobe would change a register there.

// File: rtl/dp_pkg.sv
package dp_pkg;
   typedef enum logic [3:0] {
      OP_MOVA = 4'd0,
      OP_ZERO = 4'd1,
      OP_NOTA = 4'd2,
      OP_SHL  = 4'd3,
      OP_SHR  = 4'd4,
      OP_ADD  = 4'd5,
      OP_SUB  = 4'd6,
      OP_AND  = 4'd7,
      OP_OR   = 4'd8,
      OP_XOR  = 4'd9,
      OP_EXT  = 4'd10
   } dp_op_e;
   localparam int OP_W = 4;
endpackage

// File: rtl/dp_decoder.sv
module dp_decoder #(
   parameter int DEPTH = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             en,
   input  logic [IDX_W-1:0] idx,
   output logic [DEPTH-1:0] onehot
);
   for (genvar g = 0; g < DEPTH; g++) begin : g_line
      assign onehot[g] = en && (idx == IDX_W'(g));
   end
endmodule

// File: rtl/dp_select.sv
module dp_select #(
   parameter int WIDTH = 16,
   parameter int DEPTH = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic [DEPTH*WIDTH-1:0] bank,
   input  logic [IDX_W-1:0]       sel,
   output logic [WIDTH-1:0]       word
);
   always_comb begin
      word = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (sel == IDX_W'(k)) word = bank[k*WIDTH +: WIDTH];
      end
   end
endmodule

// File: rtl/dp_regbank.sv
module dp_regbank #(
   parameter int WIDTH = 16,
   parameter int DEPTH = 8
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [DEPTH-1:0]       load,
   input  logic [WIDTH-1:0]       din,
   output logic [DEPTH*WIDTH-1:0] bank
);
   for (genvar g = 0; g < DEPTH; g++) begin : g_reg
      logic [WIDTH-1:0] q;
      always_ff @(posedge clk) begin
         if (rst)          q <= '0;
         else if (load[g]) q <= din;
      end
      assign bank[g*WIDTH +: WIDTH] = q;
   end
endmodule

// File: rtl/dp_units.sv
module dp_units
   import dp_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic [WIDTH-1:0] ext,
   input  logic [OP_W-1:0]  code,
   output logic [WIDTH-1:0] result,
   output logic             cflag,
   output logic             cflag_upd
);
   logic [WIDTH:0] sum_w;
   logic [WIDTH:0] dif_w;

   assign sum_w = {1'b0, opa} + {1'b0, opb};
   assign dif_w = {1'b0, opa} - {1'b0, opb};

   always_comb begin
      cflag     = 1'b0;
      cflag_upd = 1'b0;
      unique case (dp_op_e'(code))
         OP_MOVA: result = opa;
         OP_ZERO: result = '0;
         OP_NOTA: result = ~opa;
         OP_SHL:  result = {opa[WIDTH-2:0], 1'b0};
         OP_SHR:  result = {1'b0, opa[WIDTH-1:1]};
         OP_ADD: begin
            result    = sum_w[WIDTH-1:0];
            cflag     = sum_w[WIDTH];
            cflag_upd = 1'b1;
         end
         OP_SUB: begin
            result    = dif_w[WIDTH-1:0];
            cflag     = dif_w[WIDTH];
            cflag_upd = 1'b1;
         end
         OP_AND:  result = opa & opb;
         OP_OR:   result = opa | opb;
         OP_XOR:  result = opa ^ opb;
         OP_EXT:  result = ext;
         default: result = '0;
      endcase
   end
endmodule

// File: rtl/regarray_datapath.sv
module regarray_datapath
   import dp_pkg::*;
#(
   parameter int WIDTH = 16,
   parameter int DEPTH = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] src_a,
   input  logic [IDX_W-1:0] src_b,
   input  logic [IDX_W-1:0] dst,
   input  logic [OP_W-1:0]  op,
   input  logic [WIDTH-1:0] ext_data,
   input  logic [IDX_W-1:0] rd_sel,
   output logic [WIDTH-1:0] rd_data,
   output logic             carry
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (WIDTH < 2) begin : g_bad_width
      $error("WIDTH must be at least 2");
   end

   logic [DEPTH*WIDTH-1:0] bank;
   logic [DEPTH-1:0]       we_vec;
   logic [WIDTH-1:0]       a_word, b_word, res_bus;
   logic                   c_next, c_upd;

   dp_decoder #(.DEPTH(DEPTH)) u_dec (
      .en(wr_en), .idx(dst), .onehot(we_vec));

   dp_regbank #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_bank (
      .clk(clk), .rst(rst), .load(we_vec), .din(res_bus), .bank(bank));

   dp_select #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_sel_a (
      .bank(bank), .sel(src_a), .word(a_word));
   dp_select #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_sel_b (
      .bank(bank), .sel(src_b), .word(b_word));
   dp_select #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_sel_rd (
      .bank(bank), .sel(rd_sel), .word(rd_data));

   dp_units #(.WIDTH(WIDTH)) u_units (
      .opa(a_word), .opb(b_word), .ext(ext_data), .code(op),
      .result(res_bus), .cflag(c_next), .cflag_upd(c_upd));

   always_ff @(posedge clk) begin
      if (rst)                 carry <= 1'b0;
      else if (wr_en && c_upd) carry <= c_next;
   end
endmodule

// File: rtl/dp_checker.sv
module dp_checker
   import dp_pkg::*;
#(
   parameter int WIDTH = 16,
   parameter int DEPTH = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input logic             clk,
   input logic             rst,
   input logic             wr_en,
   input logic [IDX_W-1:0] dst,
   input logic [OP_W-1:0]  op,
   input logic [WIDTH-1:0] ext_data,
   input logic [IDX_W-1:0] rd_sel,
   input logic [WIDTH-1:0] rd_data,
   input logic             carry,
   input logic [DEPTH-1:0] we_vec,
   input logic [WIDTH-1:0] res_bus
);
   assert_enable_onehot_R4: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> $countones(we_vec) == 1);

   assert_no_enable_idle_R3: assert property (@(posedge clk) disable iff (rst)
      !wr_en |-> we_vec == '0);

   assert_carry_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && (op == OP_ADD || op == OP_SUB)) |=> $stable(carry));

   assert_write_visible_R2: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> (rd_sel != $past(dst)) || (rd_data == $past(res_bus)));

   assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (rd_data == '0 && !carry));

   assert_ext_on_bus_R9: assert property (@(posedge clk) disable iff (rst)
      op == OP_EXT |-> res_bus == ext_data);
endmodule

bind regarray_datapath dp_checker #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst(rst), .wr_en(wr_en), .dst(dst), .op(op),
   .ext_data(ext_data), .rd_sel(rd_sel), .rd_data(rd_data), .carry(carry),
   .we_vec(we_vec), .res_bus(res_bus));

// File: tb/test_regarray_datapath.sv
module test_regarray_datapath;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [2:0]  src_a = '0, src_b = '0, dst = '0, rd_sel = '0;
   logic [3:0]  op = '0;
   logic [15:0] ext_data = '0;
   logic [15:0] rd_data;
   logic        carry;

   int checks = 0;
   int fails = 0;
   int cycles = 0;
   logic [15:0] m [8];
   logic        mc;

   regarray_datapath i_regarray_datapath (
      .clk(clk), .rst(rst), .wr_en(wr_en), .src_a(src_a), .src_b(src_b),
      .dst(dst), .op(op), .ext_data(ext_data), .rd_sel(rd_sel),
      .rd_data(rd_data), .carry(carry));

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual %0d cycles expected < 5000", cycles);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   // Reference result and carry computed from the requirements.
   function automatic logic [16:0] ref_op(input int code, input int a,
                                          input int b, input int e);
      int r; int c; r = 0; c = -1;
      case (code)
         0: r = a;
         1: r = 0;
         2: r = ~a;
         3: r = a * 2;
         4: r = a / 2;
         5: begin r = a + b; c = (a + b) >= 65536 ? 1 : 0; end
         6: begin r = a - b; c = (a < b) ? 1 : 0; end
         7: r = a & b;
         8: r = a | b;
         9: r = a ^ b;
         10: r = e;
         default: r = 0;
      endcase
      return {(c == 1), 16'(r & 16'hFFFF)};
   endfunction

   task automatic compare(input string tag);
      for (int i = 0; i < 8; i++) begin
         rd_sel = 3'(i);
         #1;
         checks++;
         if (rd_data !== m[i]) begin
            fails++;
            $display("FAIL %s reg%0d: actual %h expected %h", tag, i, rd_data, m[i]);
         end
      end
      checks++;
      if (carry !== mc) begin
         fails++;
         $display("FAIL %s carry: actual %b expected %b", tag, carry, mc);
      end
   endtask

   // Drive one microoperation in the low phase, update the model at the edge,
   // then compare every register in the next low phase.
   task automatic step(input string tag, input bit r, input bit we, input int code,
                       input int a, input int b, input int d, input int e);
      logic [16:0] res;
      rst = r; wr_en = we; op = 4'(code); src_a = 3'(a); src_b = 3'(b);
      dst = 3'(d); ext_data = 16'(e);
      res = ref_op(code, int'(m[a]), int'(m[b]), e);
      @(posedge clk);
      if (r) begin
         for (int i = 0; i < 8; i++) m[i] = '0;
         mc = 1'b0;
      end else if (we) begin
         m[d] = res[15:0];
         if (code == 5 || code == 6) mc = res[16];
      end
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) m[i] = 16'hxxxx;
      mc = 1'bx;
      // R1: reset clears all
      step("R1 reset", 1, 0, 0, 0, 0, 0, 0);
      step("R1 reset", 1, 1, 10, 0, 0, 3, 16'h1234);
      // R9: load through external bus
      step("R9 ext", 0, 1, 10, 0, 0, 0, 16'hFFFF);
      step("R9 ext", 0, 1, 10, 0, 0, 1, 16'h0001);
      step("R9 ext", 0, 1, 10, 0, 0, 2, 16'h8001);
      step("R9 ext", 0, 1, 10, 0, 0, 3, 16'h00F0);
      step("R9 ext", 0, 1, 10, 0, 0, 4, 16'h3C5A);
      // R7 R8: add overflow sets carry
      step("R7 add", 0, 1, 5, 0, 1, 5, 0);
      // R8: logic write keeps carry
      step("R8 hold", 0, 1, 7, 0, 4, 6, 0);
      step("R7 add", 0, 1, 5, 1, 3, 7, 0);
      // R7 R8: subtract borrow then no borrow
      step("R7 sub", 0, 1, 6, 1, 4, 6, 0);
      step("R7 sub", 0, 1, 6, 4, 1, 6, 0);
      step("R7 or", 0, 1, 8, 3, 4, 7, 0);
      step("R7 xor", 0, 1, 9, 2, 4, 7, 0);
      // R6: single-register operations, top and bottom bits set
      step("R6 shl", 0, 1, 3, 2, 0, 5, 0);
      step("R6 shr", 0, 1, 4, 2, 0, 5, 0);
      step("R6 not", 0, 1, 2, 4, 0, 5, 0);
      step("R6 mov", 0, 1, 0, 2, 0, 6, 0);
      step("R6 zero", 0, 1, 1, 0, 0, 6, 0);
      // R5 R10: same register as both operands and destination
      step("R10 self", 0, 1, 5, 4, 4, 4, 0);
      step("R5 R10 self", 0, 1, 3, 4, 0, 4, 0);
      // R9: reserved code gives zero
      step("R9 reserved", 0, 1, 13, 1, 1, 3, 16'hBEEF);
      // R3: strobe low changes nothing
      step("R3 idle", 0, 0, 10, 0, 0, 2, 16'h5555);
      step("R3 idle", 0, 0, 5, 0, 0, 0, 0);
      // R4: writes into every index
      for (int i = 0; i < 8; i++) step("R4 walk", 0, 1, 10, 0, 0, i, 16'h1111 * (i + 1));
      step("R2 add", 0, 1, 5, 7, 6, 0, 0);
      // R1: reset mid-run with a write pending
      step("R1 midreset", 1, 1, 10, 0, 0, 5, 16'hAAAA);
      step("R2 after reset", 0, 1, 10, 0, 0, 5, 16'h0042);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule